// File: doc/BRIEF.md
# Asymmetric Decode Slot Allocator

The allocator sits between two per-thread instruction queues and a row of five decoder slots. Each cycle it picks one hardware thread. It then takes instructions in program order from the head of that thread's queue and assigns each one to a decoder slot. Slot 0 is the only slot that can expand an instruction into several fused micro-ops. Slots 1 to 4 take only single-micro-op instructions. Every extra micro-op expanded in slot 0 removes one simple slot from the cycle, so the micro-op output never exceeds the slot count.

Each queue shows its first five entries to the allocator. Each entry carries a valid bit, a micro-op count and an opaque payload. An entry whose count is above the complex limit is passed on alone, as a request for long-sequence expansion. The result is a registered group. It holds a valid bit, a count and a payload per slot, plus the number of entries consumed, the thread of the group and the expansion-request flag. The queue owner uses the consumed count to pop its head.

Top module: `decode_slot_alloc`

## Requirements
- R1: Slot 0 accepts the first queue entry with a micro-op count from 1 to 4. A count of 0 is handled as one micro-op, and slot 0 reports the handled count.
- R2: Slots 1 to 4 accept only entries whose handled count is one. Acceptance stops at the first later entry with a larger count, and that entry is not consumed.
- R3: When slot 0 holds an entry of k micro-ops, at most 5-k simple slots are filled. The total micro-op count of a normal group is at most 5.
- R4: Entries are taken strictly in order. Queue entry j goes to slot j, where valid bit j, count bits [3j+2:3j] and payload bits [8j+7:8j] belong to entry j. Acceptance stops at the first invalid entry.
- R5: A first entry with a count above 4 raises the expansion-request output. It occupies slot 0 alone with its raw count, and the consumed count is 1.
- R6: A thread is eligible when its ready bit is set and its entry 0 is valid. When both threads are eligible, the served thread alternates every cycle. The first group after reset comes from thread 0.
- R7: When the preferred thread is not eligible, the other eligible thread is served. When neither is eligible, the group is empty: all slot outputs are zero, the consumed count is 0, the thread output is 0, and the alternation state is kept.
- R8: The consumed count equals the number of valid slots. The thread output names the thread whose entries fill the group.
- R9: All outputs are registered and reflect the inputs sampled at the previous rising clock edge. During reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| thr_rdy_i | input | 2 | Per-thread ready, bit t for thread t |
| t0_vld_i | input | 5 | Thread 0 head entry valid bits |
| t0_ucnt_i | input | 15 | Thread 0 micro-op counts, 3 bits per entry |
| t0_pld_i | input | 40 | Thread 0 payloads, 8 bits per entry |
| t1_vld_i | input | 5 | Thread 1 head entry valid bits |
| t1_ucnt_i | input | 15 | Thread 1 micro-op counts, 3 bits per entry |
| t1_pld_i | input | 40 | Thread 1 payloads, 8 bits per entry |
| slot_vld_o | output | 5 | Per-slot valid |
| slot_ucnt_o | output | 15 | Per-slot micro-op count |
| slot_pld_o | output | 40 | Per-slot payload |
| consumed_o | output | 3 | Entries popped from the served queue |
| tid_o | output | 1 | Thread of the group |
| rom_req_o | output | 1 | Long-sequence expansion request in slot 0 |

## Verification
Thread choice and slot budgeting resolve in the same cycle. A fallback to the other thread can therefore coincide with a complex first entry that trims the simple slots, or with an expansion request that blocks them all. The bench drives one thread not ready while the other holds a multi-micro-op head, and it also mixes random ready bits with random counts. A reference model tracks the alternation state separately from the design and predicts the thread, valid mask, counts and payloads. Each prediction is compared against the registered group one edge later.

// File: rtl/das_pkg.sv
package das_pkg;
  typedef enum logic {THR_A = 1'b0, THR_B = 1'b1} thr_e;

  // zero-count entries are treated as single micro-op
  function automatic int eff_cnt(input int c);
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/das_thread_pick.sv
module das_thread_pick
  import das_pkg::*;
(
  input  logic [1:0] elig_i,
  input  thr_e       last_i,
  output logic       go_o,
  output thr_e       sel_o,
  output thr_e       last_nxt_o
);
  thr_e pref, alt;

  always_comb begin
    pref = (last_i == THR_A) ? THR_B : THR_A;
    alt  = last_i;
    go_o = 1'b0;
    sel_o = pref;
    if (elig_i[pref]) begin
      go_o = 1'b1;
    end else if (elig_i[alt]) begin
      go_o  = 1'b1;
      sel_o = alt;
    end
    last_nxt_o = go_o ? sel_o : last_i;
  end
endmodule

// File: rtl/das_group_build.sv
module das_group_build
  import das_pkg::*;
#(
  parameter int SLOTS     = 5,
  parameter int CNT_W     = 3,
  parameter int PLD_W     = 8,
  parameter int MAX_CPLX  = 4,
  parameter int CONS_W    = 3
) (
  input  logic                   go_i,
  input  logic [SLOTS-1:0]       vld_i,
  input  logic [SLOTS*CNT_W-1:0] ucnt_i,
  input  logic [SLOTS*PLD_W-1:0] pld_i,
  output logic [SLOTS-1:0]       slot_vld_o,
  output logic [SLOTS*CNT_W-1:0] slot_ucnt_o,
  output logic [SLOTS*PLD_W-1:0] slot_pld_o,
  output logic [CONS_W-1:0]      consumed_o,
  output logic                   rom_o
);
  logic [CNT_W-1:0] cnt [SLOTS];
  logic [SLOTS-1:0] ok;
  int               k0;
  logic             rom;

  for (genvar g = 0; g < SLOTS; g++) begin : g_unpack
    assign cnt[g] = ucnt_i[g*CNT_W +: CNT_W];
  end

  always_comb begin
    k0    = eff_cnt(int'(cnt[0]));
    rom   = go_i && vld_i[0] && (k0 > MAX_CPLX);
    ok    = '0;
    ok[0] = go_i && vld_i[0];
    for (int j = 1; j < SLOTS; j++) begin
      // each extra complex uop removes one simple slot
      ok[j] = ok[j-1] && vld_i[j] && !rom &&
              (eff_cnt(int'(cnt[j])) == 1) && (j <= SLOTS - k0);
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_ucnt_o[g*CNT_W +: CNT_W] =
      ok[g] ? CNT_W'(eff_cnt(int'(cnt[g]))) : '0;
    assign slot_pld_o[g*PLD_W +: PLD_W] = ok[g] ? pld_i[g*PLD_W +: PLD_W] : '0;
  end

  assign slot_vld_o = ok;
  assign consumed_o = CONS_W'($countones(ok));
  assign rom_o      = rom;
endmodule

// File: rtl/decode_slot_alloc.sv
module decode_slot_alloc
  import das_pkg::*;
#(
  parameter int SLOTS    = 5,
  parameter int CNT_W    = 3,
  parameter int PLD_W    = 8,
  parameter int MAX_CPLX = 4,
  localparam int CONS_W  = $clog2(SLOTS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             thr_rdy_i,
  input  logic [SLOTS-1:0]       t0_vld_i,
  input  logic [SLOTS*CNT_W-1:0] t0_ucnt_i,
  input  logic [SLOTS*PLD_W-1:0] t0_pld_i,
  input  logic [SLOTS-1:0]       t1_vld_i,
  input  logic [SLOTS*CNT_W-1:0] t1_ucnt_i,
  input  logic [SLOTS*PLD_W-1:0] t1_pld_i,
  output logic [SLOTS-1:0]       slot_vld_o,
  output logic [SLOTS*CNT_W-1:0] slot_ucnt_o,
  output logic [SLOTS*PLD_W-1:0] slot_pld_o,
  output logic [CONS_W-1:0]      consumed_o,
  output logic                   tid_o,
  output logic                   rom_req_o
);
  logic [1:0]             elig;
  logic                   go;
  thr_e                   sel, last_q, last_nxt;
  logic [SLOTS-1:0]       s_vld;
  logic [SLOTS*CNT_W-1:0] s_ucnt;
  logic [SLOTS*PLD_W-1:0] s_pld;
  logic [SLOTS-1:0]       g_vld;
  logic [SLOTS*CNT_W-1:0] g_ucnt;
  logic [SLOTS*PLD_W-1:0] g_pld;
  logic [CONS_W-1:0]      g_cons;
  logic                   g_rom;

  assign elig[0] = thr_rdy_i[0] && t0_vld_i[0];
  assign elig[1] = thr_rdy_i[1] && t1_vld_i[0];

  das_thread_pick u_pick (
    .elig_i     (elig),
    .last_i     (last_q),
    .go_o       (go),
    .sel_o      (sel),
    .last_nxt_o (last_nxt)
  );

  always_comb begin
    if (sel == THR_B) begin
      s_vld = t1_vld_i; s_ucnt = t1_ucnt_i; s_pld = t1_pld_i;
    end else begin
      s_vld = t0_vld_i; s_ucnt = t0_ucnt_i; s_pld = t0_pld_i;
    end
  end

  das_group_build #(
    .SLOTS(SLOTS), .CNT_W(CNT_W), .PLD_W(PLD_W),
    .MAX_CPLX(MAX_CPLX), .CONS_W(CONS_W)
  ) u_build (
    .go_i        (go),
    .vld_i       (s_vld),
    .ucnt_i      (s_ucnt),
    .pld_i       (s_pld),
    .slot_vld_o  (g_vld),
    .slot_ucnt_o (g_ucnt),
    .slot_pld_o  (g_pld),
    .consumed_o  (g_cons),
    .rom_o       (g_rom)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q      <= THR_B;   // first pick is thread 0
      slot_vld_o  <= '0;
      slot_ucnt_o <= '0;
      slot_pld_o  <= '0;
      consumed_o  <= '0;
      tid_o       <= 1'b0;
      rom_req_o   <= 1'b0;
    end else begin
      last_q      <= last_nxt;
      slot_vld_o  <= g_vld;
      slot_ucnt_o <= g_ucnt;
      slot_pld_o  <= g_pld;
      consumed_o  <= g_cons;
      tid_o       <= go ? sel : 1'b0;
      rom_req_o   <= g_rom;
    end
  end
endmodule

// File: rtl/das_chk.sv
module das_chk #(
  parameter int SLOTS    = 5,
  parameter int CNT_W    = 3,
  parameter int MAX_CPLX = 4,
  parameter int CONS_W   = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [1:0]             thr_rdy_i,
  input logic [SLOTS-1:0]       t0_vld_i,
  input logic [SLOTS-1:0]       t1_vld_i,
  input logic [SLOTS-1:0]       slot_vld_o,
  input logic [SLOTS*CNT_W-1:0] slot_ucnt_o,
  input logic [CONS_W-1:0]      consumed_o,
  input logic                   rom_req_o
);
  int   usum;
  logic simple_one;
  logic any_elig;
  logic [CNT_W-1:0] c0;

  always_comb begin
    usum = 0;
    simple_one = 1'b1;
    for (int j = 0; j < SLOTS; j++) begin
      if (slot_vld_o[j]) usum += int'(slot_ucnt_o[j*CNT_W +: CNT_W]);
      if (j > 0 && slot_vld_o[j] && slot_ucnt_o[j*CNT_W +: CNT_W] != CNT_W'(1))
        simple_one = 1'b0;
    end
    any_elig = (thr_rdy_i[0] && t0_vld_i[0]) || (thr_rdy_i[1] && t1_vld_i[0]);
    c0 = slot_ucnt_o[CNT_W-1:0];
  end

  AST_CPLX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_o[0] && !rom_req_o) |-> (c0 >= 1 && int'(c0) <= MAX_CPLX)); // R1
  AST_SIMPLE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    simple_one); // R2
  AST_UOP_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_req_o |-> usum <= SLOTS); // R3
  AST_IN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((slot_vld_o + 1'b1) & slot_vld_o) == '0); // R4
  AST_ROM_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_req_o |-> (slot_vld_o == SLOTS'(1) && consumed_o == CONS_W'(1))); // R5
  AST_IDLE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!any_elig) |-> slot_vld_o == '0); // R7
  AST_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(consumed_o) == $countones(slot_vld_o)); // R8
endmodule

bind decode_slot_alloc das_chk #(
  .SLOTS(SLOTS), .CNT_W(CNT_W), .MAX_CPLX(MAX_CPLX), .CONS_W(CONS_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .thr_rdy_i   (thr_rdy_i),
  .t0_vld_i    (t0_vld_i),
  .t1_vld_i    (t1_vld_i),
  .slot_vld_o  (slot_vld_o),
  .slot_ucnt_o (slot_ucnt_o),
  .consumed_o  (consumed_o),
  .rom_req_o   (rom_req_o)
);

// File: tb/sim_decode_slot_alloc.sv
`timescale 1ns/1ps
module sim_decode_slot_alloc;
  typedef struct packed {
    logic [4:0]  vld;
    logic [14:0] ucnt;
    logic [39:0] pld;
    logic [2:0]  cons;
    logic        tid;
    logic        rom;
  } grp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rdy = '0;
  logic [4:0]  v0 = '0, v1 = '0;
  logic [14:0] c0 = '0, c1 = '0;
  logic [39:0] p0 = '0, p1 = '0;
  logic [4:0]  o_vld;
  logic [14:0] o_ucnt;
  logic [39:0] o_pld;
  logic [2:0]  o_cons;
  logic        o_tid, o_rom;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  logic  m_last = 1'b1;
  grp_t  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  decode_slot_alloc u0 (
    .clk_i(clk), .rst_ni(rst_n), .thr_rdy_i(rdy),
    .t0_vld_i(v0), .t0_ucnt_i(c0), .t0_pld_i(p0),
    .t1_vld_i(v1), .t1_ucnt_i(c1), .t1_pld_i(p1),
    .slot_vld_o(o_vld), .slot_ucnt_o(o_ucnt), .slot_pld_o(o_pld),
    .consumed_o(o_cons), .tid_o(o_tid), .rom_req_o(o_rom)
  );

  function automatic logic [14:0] pk(int a, int b, int c, int d, int e);
    return {3'(e), 3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  function automatic int ef(logic [2:0] c);
    return (c == 0) ? 1 : int'(c);
  endfunction

  // reference model built from the requirements
  function automatic grp_t model();
    grp_t g = '0;
    logic [1:0] el;
    logic pref, sel, go;
    logic [4:0] v;
    logic [14:0] c;
    logic [39:0] p;
    int k;
    bit run;
    el = {rdy[1] & v1[0], rdy[0] & v0[0]};
    pref = ~m_last;
    go = 1'b1;
    if (el[pref]) sel = pref;
    else if (el[~pref]) sel = ~pref;
    else begin go = 1'b0; sel = 1'b0; end
    if (!go) return g;
    m_last = sel;
    g.tid = sel;
    v = sel ? v1 : v0; c = sel ? c1 : c0; p = sel ? p1 : p0;
    k = ef(c[2:0]);
    g.vld[0] = 1'b1;
    g.ucnt[2:0] = 3'(k);
    g.pld[7:0] = p[7:0];
    g.cons = 3'd1;
    if (k > 4) begin g.rom = 1'b1; return g; end
    run = 1;
    for (int j = 1; j < 5; j++) begin
      if (run && v[j] && ef(c[j*3 +: 3]) == 1 && j <= 5 - k) begin
        g.vld[j] = 1'b1;
        g.ucnt[j*3 +: 3] = 3'd1;
        g.pld[j*8 +: 8] = p[j*8 +: 8];
        g.cons = g.cons + 3'd1;
      end else run = 0;
    end
    return g;
  endfunction

  task automatic drv(string tag, logic [1:0] r, logic [4:0] a_v, logic [14:0] a_c,
                     logic [4:0] b_v, logic [14:0] b_c);
    @(negedge clk);
    rdy = r; v0 = a_v; c0 = a_c; v1 = b_v; c1 = b_c;
    p0 = {$urandom, $urandom};
    p1 = {$urandom, $urandom};
    exp_q.push_back(model());
    tag_q.push_back(tag);
  endtask

  // monitor: compare one edge after each drive
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        grp_t e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = '{o_vld, o_ucnt, o_pld, o_cons, o_tid, o_rom};
        n_cmp++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: got vld=%b cnt=%h pld=%h cons=%0d tid=%0d rom=%b exp vld=%b cnt=%h pld=%h cons=%0d tid=%0d rom=%b",
                   t, a.vld, a.ucnt, a.pld, a.cons, a.tid, a.rom,
                   e.vld, e.ucnt, e.pld, e.cons, e.tid, e.rom);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if ({o_vld, o_ucnt, o_pld, o_cons, o_tid, o_rom} !== '0) begin
      n_bad++;
      $display("FAIL R9 reset: got vld=%b cons=%0d expected all zero", o_vld, o_cons);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R6 alternation, all single-uop, first is thread 0; R4 full width
    drv("R6_R4 all single t0", 2'b11, 5'h1f, pk(1,1,1,1,1), 5'h1f, pk(1,1,1,1,1));
    drv("R6 alternate t1",     2'b11, 5'h1f, pk(1,1,1,1,1), 5'h1f, pk(1,1,1,1,1));
    // R3 budgets
    drv("R3 k2 three simple",  2'b11, 5'h1f, pk(2,1,1,1,1), 5'h1f, pk(1,1,1,1,1));
    drv("R3 k3 two simple",    2'b11, 5'h1f, pk(1,1,1,1,1), 5'h1f, pk(3,1,1,1,1));
    drv("R3 k4 one simple",    2'b11, 5'h1f, pk(4,1,1,1,1), 5'h1f, pk(1,1,1,1,1));
    // R2 multi-uop later stops acceptance
    drv("R2 stop at entry2",   2'b11, 5'h1f, pk(1,1,1,1,1), 5'h1f, pk(1,1,2,1,1));
    // R4 invalid entry stops
    drv("R4 hole at entry3",   2'b11, 5'h17, pk(1,1,1,1,1), 5'h1f, pk(1,1,1,1,1));
    // R1 zero count
    drv("R1 zero count",       2'b11, 5'h1f, pk(1,1,1,1,1), 5'h1f, pk(0,0,1,1,1));
    // R5 expansion request
    drv("R5 rom request",      2'b11, 5'h1f, pk(6,1,1,1,1), 5'h1f, pk(1,1,1,1,1));
    drv("R5 rom count 7",      2'b11, 5'h1f, pk(1,1,1,1,1), 5'h1f, pk(7,1,1,1,1));
    // R7 fallback with complex head, then idle
    drv("R7 t1 not ready",     2'b01, 5'h1f, pk(2,1,1,1,1), 5'h1f, pk(1,1,1,1,1));
    drv("R7 t1 not ready again", 2'b01, 5'h1f, pk(5,1,1,1,1), 5'h1f, pk(1,1,1,1,1));
    drv("R7 t0 head invalid",  2'b11, 5'h1e, pk(1,1,1,1,1), 5'h03, pk(3,1,1,1,1));
    drv("R7 none eligible",    2'b00, 5'h1f, pk(1,1,1,1,1), 5'h1f, pk(1,1,1,1,1));
    drv("R8 after idle",       2'b11, 5'h07, pk(1,1,1,1,1), 5'h01, pk(1,1,1,1,1));
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [14:0] ra, rb;
      ra = 15'($urandom); rb = 15'($urandom);
      if ($urandom_range(0, 1) == 1) ra = pk($urandom_range(0, 4), 1, 1, $urandom_range(0, 2), 1);
      if ($urandom_range(0, 1) == 1) rb = pk($urandom_range(0, 4), 1, $urandom_range(0, 2), 1, 1);
      drv("R8_R3 random", 2'($urandom), 5'($urandom) | 5'h1, ra, 5'($urandom), rb);
    end
    @(negedge clk);
    rdy = '0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule